// File: doc/BRIEF.md
# Multiplexed Four-Digit Seven-Segment Driver

This block lights a four-position, common-anode seven-segment display using one packed 20-bit input word. That word holds one 5-bit field per position. Each field is a 4-bit BCD value and a decimal-point flag. The display is time-multiplexed. At any moment one position has its anode pulled low, and the eight cathode lines carry the pattern for that position. A prescaler steps through the positions in order. By default the prescaler advances every 100,000 cycles of a 100 MHz clock. That gives 1 ms per position and 4 ms for a full sweep, which sits inside the allowed 1 ms to 16 ms refresh window.

The driver has a synchronous active-high reset and an enable input. Both blank the display. The enable input also freezes the scan wherever it is. The block registers its outputs, so anode and cathode values always change on the same clock edge.

Top module: `seg_mux_driver`

## Requirements
- R1: A clock edge with `rst` high drives `anOut` to 4'b1111 and `segOut` to 8'hFF. After reset the scan begins at position 0 with a full dwell period.
- R2: A clock edge with `en` low and `rst` low drives `anOut` to 4'b1111 and `segOut` to 8'hFF. The dwell count and the position index keep their values, and the scan resumes from that point when `en` returns high.
- R3: While enabled, each position stays selected for exactly DWELL clocks. The position index then steps 0, 1, 2, 3 and wraps back to 0.
- R4: `anOut` is active low. While enabled, exactly one bit is low, and bit k low selects position k (position 0 is the rightmost).
- R5: Position k takes its BCD value from `din[5k+3:5k]` and its decimal-point flag from `din[5k+4]`.
- R6: `segOut` is active low, with bit order {dp, g, f, e, d, c, b, a} (bit 0 = a). BCD values 0 to 9 give the standard digit shapes. With a = bit 0, the lit-segment masks for 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R7: BCD codes 10 to 15 turn off all of `segOut[6:0]`. The decimal point still follows its own flag.
- R8: `segOut[7]` is low exactly when the selected field's decimal-point flag is 1.
- R9: The outputs are registered. The values shown after an edge are derived from the position index and `din` present before that edge, and `anOut` and `segOut` always change on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Driver enable; low blanks the display and freezes the scan |
| din | input | 20 | Four 5-bit fields {dp, bcd[3:0]}, field 0 in the low bits |
| segOut | output | 8 | Cathode drive, active low, {dp, g, f, e, d, c, b, a} |
| anOut | output | 4 | Anode drive, active low, bit k selects position k |

## Verification
A position index that is wrong shows up on `anOut` on the very next edge, because the anode pattern is a direct registered image of the index. A prescaler count that drifts shows up as a dwell that is longer or shorter than DWELL clocks. It therefore becomes visible at the next position change, at most DWELL cycles later. The bench runs with a short dwell so that many wraps, freezes and mid-dwell data changes fit into one run. It compares both output buses on every clock against a behavioural model of the scan.

// File: rtl/seg_mux_pkg.sv
package seg_mux_pkg;

  localparam int unsigned NUM_DIGITS = 4;
  localparam int unsigned BCD_BITS   = 4;
  localparam int unsigned FIELD_BITS = BCD_BITS + 1;
  localparam int unsigned DIN_BITS   = NUM_DIGITS * FIELD_BITS;
  localparam int unsigned SEG_BITS   = 8;
  localparam int unsigned SEL_BITS   = $clog2(NUM_DIGITS);

  // strobes from the scan control to the output datapath
  typedef struct packed {
    logic                blank;
    logic [SEL_BITS-1:0] sel;
  } scan_strobe_t;

  // active-high segment mask, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] glyph_of(input logic [BCD_BITS-1:0] code);
    logic [6:0] m;
    case (code)
      4'd0:    m = 7'b0111111;
      4'd1:    m = 7'b0000110;
      4'd2:    m = 7'b1011011;
      4'd3:    m = 7'b1001111;
      4'd4:    m = 7'b1100110;
      4'd5:    m = 7'b1101101;
      4'd6:    m = 7'b1111101;
      4'd7:    m = 7'b0000111;
      4'd8:    m = 7'b1111111;
      4'd9:    m = 7'b1101111;
      default: m = 7'b0000000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
  import seg_mux_pkg::*;
#(
  parameter int unsigned DWELL = 100000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output scan_strobe_t strobe
);

  localparam int unsigned CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1;
  localparam logic [CNT_W-1:0]    CNT_LAST = CNT_W'(DWELL - 1);
  localparam logic [SEL_BITS-1:0] SEL_LAST = SEL_BITS'(NUM_DIGITS - 1);

  logic [CNT_W-1:0]    dwellCnt;
  logic [SEL_BITS-1:0] digitIdx;
  logic                scanTick;

  assign scanTick = en && (dwellCnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      dwellCnt <= '0;
      digitIdx <= '0;
    end else if (en) begin
      if (scanTick) begin
        dwellCnt <= '0;
        digitIdx <= (digitIdx == SEL_LAST) ? '0 : digitIdx + 1'b1;
      end else begin
        dwellCnt <= dwellCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.blank = !en;
    strobe.sel   = digitIdx;
  end

endmodule

// File: rtl/seg_disp_path.sv
module seg_disp_path
  import seg_mux_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIN_BITS-1:0]   din,
  input  scan_strobe_t          strobe,
  output logic [SEG_BITS-1:0]   segOut,
  output logic [NUM_DIGITS-1:0] anOut
);

  logic [BCD_BITS-1:0]   bcdField [NUM_DIGITS];
  logic                  dpField  [NUM_DIGITS];
  logic [BCD_BITS-1:0]   bcdSel;
  logic                  dpSel;
  logic [NUM_DIGITS-1:0] anNext;
  logic [SEG_BITS-1:0]   segNext;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_field
    assign bcdField[k] = din[k*FIELD_BITS +: BCD_BITS];
    assign dpField[k]  = din[k*FIELD_BITS + BCD_BITS];
  end

  always_comb begin
    bcdSel = bcdField[strobe.sel];
    dpSel  = dpField[strobe.sel];
    for (int k = 0; k < NUM_DIGITS; k++) begin
      anNext[k] = (strobe.sel != SEL_BITS'(k));
    end
    segNext = ~{dpSel, glyph_of(bcdSel)};
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.blank) begin
      anOut  <= '1;
      segOut <= '1;
    end else begin
      anOut  <= anNext;
      segOut <= segNext;
    end
  end

endmodule

// File: rtl/seg_mux_driver.sv
module seg_mux_driver
  import seg_mux_pkg::*;
#(
  parameter int unsigned DWELL = 100000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [DIN_BITS-1:0]   din,
  output logic [SEG_BITS-1:0]   segOut,
  output logic [NUM_DIGITS-1:0] anOut
);

  scan_strobe_t scanCtl;

  seg_scan_ctrl #(.DWELL(DWELL)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .strobe (scanCtl)
  );

  seg_disp_path u_path (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .strobe (scanCtl),
    .segOut (segOut),
    .anOut  (anOut)
  );

endmodule

// File: rtl/seg_mux_checker.sv
module seg_mux_checker
  import seg_mux_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  en,
  input logic [DIN_BITS-1:0]   din,
  input logic [SEG_BITS-1:0]   segOut,
  input logic [NUM_DIGITS-1:0] anOut
);

  a_r1_reset_blank: assert property (@(posedge clk)
    rst |=> (anOut == '1 && segOut == '1));

  a_r2_disable_blank: assert property (@(posedge clk) disable iff (rst)
    !en |=> (anOut == '1 && segOut == '1));

  a_r4_single_anode: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~anOut));

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_pos
    a_r8_dp_follows: assert property (@(posedge clk) disable iff (rst)
      !anOut[k] |-> (segOut[7] == !$past(din[k*FIELD_BITS + BCD_BITS])));

    a_r7_code_blank: assert property (@(posedge clk) disable iff (rst)
      (!anOut[k] && ($past(din[k*FIELD_BITS +: BCD_BITS]) > 4'd9))
        |-> (segOut[6:0] == 7'h7F));
  end

endmodule

bind seg_mux_driver seg_mux_checker u_chk (.*);

// File: tb/test_seg_mux_driver.sv
module test_seg_mux_driver;

  localparam time CLK_PERIOD = 10ns;
  localparam int  DWELL_TB   = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [19:0] din;
  logic [7:0]  segOut;
  logic [3:0]  anOut;

  int total = 0;
  int bad   = 0;
  int mCnt  = 0;
  int mIdx  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_mux_driver #(.DWELL(DWELL_TB)) i_seg_mux_driver (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .segOut(segOut), .anOut(anOut)
  );

  function automatic logic [6:0] shape(input int v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: apply inputs, step the model, compare after the edge
  task automatic cyc(input logic r, input logic e, input logic [19:0] d,
                     input string tag);
    logic [3:0] expAn;
    logic [7:0] expSeg;
    int field;
    rst = r; en = e; din = d;
    @(posedge clk);
    #1;
    if (r) begin
      expAn = 4'hF; expSeg = 8'hFF; mCnt = 0; mIdx = 0;
    end else if (!e) begin
      expAn = 4'hF; expSeg = 8'hFF;
    end else begin
      field  = (d >> (5 * mIdx)) & 5'h1F;
      expAn  = ~(4'b0001 << mIdx);
      expSeg = ~{field[4], shape(field & 4'hF)};
      if (mCnt == DWELL_TB - 1) begin
        mCnt = 0; mIdx = (mIdx + 1) % 4;
      end else mCnt++;
    end
    check(anOut == expAn, tag, "anOut", {4'h0, anOut}, {4'h0, expAn});
    check(segOut == expSeg, tag, "segOut", segOut, expSeg);
    check($countones(~anOut) <= 1, "R4", "anode count",
          8'($countones(~anOut)), 8'd1);
  endtask

  function automatic logic [19:0] pack(input int d3, d2, d1, d0,
                                       input logic [3:0] dp);
    return {dp[3], 4'(d3), dp[2], 4'(d2), dp[1], 4'(d1), dp[0], 4'(d0)};
  endfunction

  initial begin
    rst = 1'b1; en = 1'b0; din = '0;
    for (int i = 0; i < 3; i++) cyc(1, 1, 20'hFFFFF, "R1");
    // scan order and dwell, field placement
    for (int i = 0; i < 45; i++) cyc(0, 1, pack(4, 3, 2, 1, 4'b0000), "R3");
    for (int i = 0; i < 22; i++) cyc(0, 1, pack(8, 7, 6, 5, 4'b0101), "R5");
    for (int i = 0; i < 22; i++) cyc(0, 1, pack(0, 9, 3, 0, 4'b1010), "R6");
    // codes above nine
    for (int i = 0; i < 22; i++) cyc(0, 1, pack(13, 12, 11, 10, 4'b1100), "R7");
    for (int i = 0; i < 22; i++) cyc(0, 1, pack(9, 15, 14, 2, 4'b0011), "R8");
    // freeze mid-dwell
    for (int i = 0; i < 3; i++) cyc(0, 1, pack(1, 2, 3, 4, 4'b0001), "R2");
    for (int i = 0; i < 7; i++) cyc(0, 0, pack(1, 2, 3, 4, 4'b0001), "R2");
    for (int i = 0; i < 24; i++) cyc(0, 1, pack(1, 2, 3, 4, 4'b0001), "R2");
    // data changing every clock
    for (int i = 0; i < 30; i++)
      cyc(0, 1, pack(i % 10, (i + 3) % 16, (i * 7) % 16, i % 16, 4'(i)), "R9");
    // reset in the middle of a dwell
    cyc(1, 1, pack(5, 5, 5, 5, 4'b1111), "R1");
    for (int i = 0; i < 25; i++) cyc(0, 1, pack(6, 7, 8, 9, 4'b1001), "R1");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule